// File: doc/BRIEF.md
# Morse Letter Player

This block flashes the Morse code of one of eight letters, S through Z, on a single LED output. A 3-bit selector picks the letter. A one-cycle start strobe captures that letter's bit pattern into a shift register. The register then plays the pattern out one bit per half-second slot. A lit slot is a 1 and a dark slot is a 0. A dot is one lit slot, a dash is three lit slots in a row, and a single dark slot separates consecutive elements.

Each pattern is 16 slots long and is padded with dark slots at the end. The pattern plays exactly once for each start strobe. The `busy` output is high for the whole playback. The half-second slot timing comes from an internal reload counter, which derives it from the `CLK_HZ` parameter.

Top module: `morse_player`

## Requirements
- R1: The letter selector maps 0..7 to S, T, U, V, W, X, Y, Z. Patterns play most significant bit first. They are:
  - S = 1010100000000000
  - T = 1110000000000000
  - U = 1010111000000000
  - V = 1010101110000000
  - W = 1011101110000000
  - X = 1110101011100000
  - Y = 1110101110111000
  - Z = 1110111010100000
- R2: Each pattern bit is shown for exactly CLK_HZ/2 clock cycles. The first bit is shown from the cycle after the start edge for a full slot.
- R3: After a start strobe, `busy` is high for exactly 16 slots (16*CLK_HZ/2 cycles) and then falls.
- R4: While `busy` is low, `led` is 0.
- R5: Once a playback has ended, the block stays idle with `led` dark until the next start strobe. The pattern never loops.
- R6: A start strobe during playback restarts it immediately with the newly selected letter and a fresh 16-slot window.
- R7: An active-low `rst_n` clears `led` and `busy` at once, without waiting for a clock edge.
- R8: Changing `letter_sel` during playback has no effect on the pattern being shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| letter_sel | input | 3 | Letter select, 0 = S through 7 = Z |
| start | input | 1 | One-cycle strobe that loads and starts playback |
| led | output | 1 | Morse on/off level |
| busy | output | 1 | High while a pattern is playing |

## Verification
The hardest situation to reach is a restart that lands at an arbitrary phase inside a slot, part-way through a pattern. In that case the slot counter and the remaining-slot count must both restart cleanly. The bench reaches it by issuing a second start after a random number of cycles into a playback, including offsets just before and just after a slot boundary. It then checks the whole new pattern cycle by cycle. The letter selector is also scrambled during playback, and an asynchronous reset is pulsed between clock edges.

// File: rtl/morse_player.sv
module morse_player #(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] letter_sel,
  input  logic       start,
  output logic       led,
  output logic       busy
);
  localparam int PAT_LEN = 16;
  localparam int HALF    = (CLK_HZ / 2 < 1) ? 1 : CLK_HZ / 2;
  localparam int DIV_W   = $clog2(HALF + 1);
  localparam int CNT_W   = $clog2(PAT_LEN + 1);

  logic [PAT_LEN-1:0] shreg;
  logic [DIV_W-1:0]   div_q;
  logic [CNT_W-1:0]   left_q;
  logic [PAT_LEN-1:0] table_pat;
  logic               tick;

  always_comb begin
    case (letter_sel)
      3'd0:    table_pat = 16'b1010100000000000;
      3'd1:    table_pat = 16'b1110000000000000;
      3'd2:    table_pat = 16'b1010111000000000;
      3'd3:    table_pat = 16'b1010101110000000;
      3'd4:    table_pat = 16'b1011101110000000;
      3'd5:    table_pat = 16'b1110101011100000;
      3'd6:    table_pat = 16'b1110101110111000;
      default: table_pat = 16'b1110111010100000;
    endcase
  end

  assign tick = (div_q == '0);
  assign busy = (left_q != '0);
  assign led  = busy & shreg[PAT_LEN-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      div_q  <= '0;
      left_q <= '0;
    end else if (start) begin
      shreg  <= table_pat;
      div_q  <= DIV_W'(HALF - 1);
      left_q <= CNT_W'(PAT_LEN);
    end else if (busy) begin
      if (tick) begin
        div_q  <= DIV_W'(HALF - 1);
        shreg  <= {shreg[PAT_LEN-2:0], 1'b0};
        left_q <= left_q - 1'b1;
      end else begin
        div_q <= div_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/morse_player_chk.sv
module morse_player_chk #(
  parameter int CLK_HZ = 50_000_000
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic led,
  input logic busy
);
  localparam int HALF  = (CLK_HZ / 2 < 1) ? 1 : CLK_HZ / 2;
  localparam int PH_W  = $clog2(HALF + 1);

  logic [PH_W-1:0] ph;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ph <= '0;
    else if (start)             ph <= '0;
    else if (ph == PH_W'(HALF - 1)) ph <= '0;
    else                        ph <= ph + 1'b1;
  end

  // R4
  idle_dark_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !led);
  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) start |=> busy);
  // R5
  no_self_start_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
  // R2
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(start) && ph != '0) |-> $stable(led));
endmodule

bind morse_player morse_player_chk #(.CLK_HZ(CLK_HZ)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .led(led), .busy(busy)
);

// File: tb/morse_player_tb_top.sv
module morse_player_tb_top;
  localparam int CLK_HZ = 8;
  localparam int H = CLK_HZ / 2;
  localparam int SLOTS = 16;

  logic clk = 0, rst_n = 0, start = 0;
  logic [2:0] letter_sel = 0;
  logic led, busy;
  int n_chk = 0, n_bad = 0;
  logic done = 0;

  always #2.5 clk = ~clk;

  morse_player #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .letter_sel(letter_sel),
    .start(start), .led(led), .busy(busy)
  );

  function automatic logic [15:0] build_pat(input logic [2:0] l);
    int ne; logic [3:0] el;
    logic [15:0] p; int pos;
    case (l)
      3'd0: begin ne = 3; el = 4'b0000; end
      3'd1: begin ne = 1; el = 4'b1000; end
      3'd2: begin ne = 3; el = 4'b0010; end
      3'd3: begin ne = 4; el = 4'b0001; end
      3'd4: begin ne = 3; el = 4'b0110; end
      3'd5: begin ne = 4; el = 4'b1001; end
      3'd6: begin ne = 4; el = 4'b1011; end
      default: begin ne = 4; el = 4'b1100; end
    endcase
    p = '0; pos = 15;
    for (int i = 0; i < ne; i++) begin
      int w = el[3-i] ? 3 : 1;
      for (int k = 0; k < w; k++) begin p[pos] = 1'b1; pos--; end
      pos--;
    end
    return p;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic kick(input logic [2:0] l);
    @(negedge clk); letter_sel = l; start = 1;
    @(posedge clk); #1 start = 0;
  endtask

  task automatic watch(input logic [2:0] l, input int cycles, input bit scramble);
    logic [15:0] p = build_pat(l);
    for (int n = 0; n < cycles; n++) begin
      @(negedge clk);
      if (scramble) letter_sel = 3'($urandom);
      check(led === p[15 - n / H], (n % H == 0) ? "R1/R2 slot bit" : "R2 hold", int'(led), int'(p[15 - n / H]));
      check(busy === 1'b1, "R3 busy during play", int'(busy), 1);
      @(posedge clk);
    end
  endtask

  task automatic expect_idle(input string req);
    @(negedge clk);
    check(busy === 1'b0, req, int'(busy), 0);
    check(led === 1'b0, req, int'(led), 0);
  endtask

  initial begin
    #(5 * 150000);
    $display("FAIL watchdog actual=0 expected=1");
    n_chk++; n_bad++;
    done = 1;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #7; check(led === 1'b0 && busy === 1'b0, "R7 reset state", int'({led, busy}), 0);
    @(negedge clk); rst_n = 1;
    for (int l = 0; l < 8; l++) begin
      kick(3'(l)); watch(3'(l), SLOTS * H, 0);
      expect_idle("R3 busy falls / R4 dark");
    end
    kick(3'd5); watch(3'd5, SLOTS * H, 1); expect_idle("R8 selector ignored");
    repeat (40) begin
      @(negedge clk);
      check(led === 1'b0 && busy === 1'b0, "R5 no replay", int'({led, busy}), 0);
    end
    kick(3'd2); watch(3'd2, H - 1, 0); kick(3'd7); watch(3'd7, SLOTS * H, 0); expect_idle("R6 restart before edge");
    kick(3'd6); watch(3'd6, H, 0); kick(3'd0); watch(3'd0, SLOTS * H, 0); expect_idle("R6 restart at edge");
    for (int r = 0; r < 60; r++) begin
      logic [2:0] a = 3'($urandom), b = 3'($urandom);
      int off = 1 + $urandom % (SLOTS * H - 1);
      kick(a); watch(a, off, r[0]);
      kick(b); watch(b, SLOTS * H, 0);
      expect_idle("R6 random restart");
    end
    kick(3'd3); watch(3'd3, 9, 0);
    #2 rst_n = 0; #0.5;
    check(led === 1'b0 && busy === 1'b0, "R7 async clear", int'({led, busy}), 0);
    @(negedge clk); rst_n = 1;
    expect_idle("R7 stays idle after reset");
    kick(3'd4); watch(3'd4, SLOTS * H, 0); expect_idle("R3 after reset");
    done = 1;
  end

  initial begin
    wait (done);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule